// File: doc/BRIEF.md
# Sequential LMS Sample Reconstructor

This block rebuilds one signed PCM sample from a four-tap adaptive linear predictor and a quantized residual. It holds the predictor state itself: a bank of history values (the last reconstructed samples) and a bank of weights. A controller fills both banks through a simple write port and can inspect them through a combinational read port. It then issues a start pulse together with a 4-bit scale-factor index and a 3-bit residual code.

The engine computes the prediction with a single multiplier. That multiplier is reused for every tap, one tap per clock, and the products are summed into a wide accumulator. The residual is dequantized through a table that stores only the positive magnitudes; odd codes take the negated magnitude of their even partner. Once the sample is formed and saturated, the block adapts every weight toward the sign of its history value and shifts the history so that the new sample becomes the newest entry. It then pulses `done` with the sample held on `sample`.

Top module: `lms_sample_engine`

## Requirements
- R1: After reset `busy`, `done` and `sample` are zero, and every history and weight entry reads back as zero.
- R2: A write with `wr_en` high while `busy` is low stores `wr_data` in bank `wr_bank` (0 = history, 1 = weights) at entry `wr_idx`. `rd_data` shows entry `rd_idx` of bank `rd_bank` in the same cycle. History entry 0 is the oldest sample and entry TAPS-1 is the newest.
- R3: The residual value for scale index s (0..15) and code q (0..7) has magnitude round(round((s+1)^2.75) * m). Here m is 0.75, 2.5, 4.5 or 7 for q>>1 = 0, 1, 2, 3. Even q gives the positive value and odd q gives its negation.
- R4: The prediction is the signed sum of history[i]*weight[i] over all taps, arithmetically shifted right by 13. The sample is the prediction plus the residual.
- R5: A sample above 32767 is output as 32767, and one below -32768 is output as -32768.
- R6: With delta = residual arithmetically shifted right by 4, each weight gains delta when its pre-update history value is non-negative and loses delta otherwise. The result wraps to 16 bits.
- R7: After a decode, history entry i takes the old entry i+1, and the newest entry takes the output sample.
- R8: A start accepted while idle raises `busy` on the next cycle. `done` rises exactly TAPS+1+MUL_STAGE cycles after the start edge (5 with defaults, within the 40-cycle budget), and `busy` falls at that same edge.
- R9: While `busy` is high, `start` and `wr_en` have no effect: no extra decode is run and no storage entry changes.
- R10: `done` is a one-cycle pulse. `sample` changes only at the edge that raises `done` and holds its value until the next decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode with the given scale index and residual code |
| sf_idx | input | SF_W | Scale-factor index |
| qr_code | input | QR_W | Quantized residual code |
| wr_en | input | 1 | Storage write strobe |
| wr_bank | input | 1 | Write bank: 0 history, 1 weights |
| wr_idx | input | IDX_W | Write entry |
| wr_data | input | DATA_W | Write value |
| rd_bank | input | 1 | Read bank: 0 history, 1 weights |
| rd_idx | input | IDX_W | Read entry |
| rd_data | output | DATA_W | Read value (combinational) |
| busy | output | 1 | A decode is in progress |
| done | output | 1 | One-cycle pulse when the sample is ready |
| sample | output | DATA_W | Last reconstructed sample |

## Verification
The bench builds the block with its defaults: 16-bit data, four taps and no product register. This makes the expected latency exactly five cycles and lets the whole residual table be swept. Every one of the 128 scale-index and code pairs is decoded against freshly loaded and then chained predictor state. This covers each table entry, both update directions of the weights and the history shift. Directed cases push the accumulator to both saturation limits and drive writes and starts into a running decode.

// File: rtl/lms_pkg.sv
package lms_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } lms_state_e;

   // rounded (s+1)^2.75 for each scale index
   function automatic int scale_base(input int s);
      case (s)
         0: return 1;      1: return 7;      2: return 21;     3: return 45;
         4: return 84;     5: return 138;    6: return 211;    7: return 304;
         8: return 421;    9: return 562;    10: return 731;   11: return 928;
         12: return 1157;  13: return 1419;  14: return 1715;  default: return 2048;
      endcase
   endfunction

   // base scaled by 0.75 / 2.5 / 4.5 / 7, rounded half up (all values positive)
   function automatic int step_mag(input int s, input int k);
      int b;
      b = scale_base(s);
      case (k)
         0: return (3 * b + 2) / 4;
         1: return (5 * b + 1) / 2;
         2: return (9 * b + 1) / 2;
         default: return 7 * b;
      endcase
   endfunction

endpackage

// File: rtl/lms_dequant_rom.sv
module lms_dequant_rom #(
   parameter int DATA_W = 16,
   parameter int SF_W   = 4,
   parameter int QR_W   = 3
) (
   input  logic [SF_W-1:0]          sf_idx,
   input  logic [QR_W-1:0]          qr_code,
   output logic signed [DATA_W-1:0] resid
);
   localparam int N_SF  = 1 << SF_W;
   localparam int N_MAG = 1 << (QR_W - 1);

   if (SF_W != 4 || QR_W != 3) begin : g_bad_shape
      $error("lms_dequant_rom: table is defined for a 4-bit scale and 3-bit code");
   end
   if (DATA_W < 16) begin : g_bad_width
      $error("lms_dequant_rom: DATA_W too small for the largest magnitude");
   end

   logic [DATA_W-1:0] mag_tab [N_SF][N_MAG];

   for (genvar s = 0; s < N_SF; s++) begin : g_sf
      for (genvar k = 0; k < N_MAG; k++) begin : g_mag
         localparam int MAG = lms_pkg::step_mag(s, k);
         assign mag_tab[s][k] = DATA_W'(MAG);
      end
   end

   logic [DATA_W-1:0] mag;
   assign mag   = mag_tab[sf_idx][qr_code[QR_W-1:1]];
   assign resid = qr_code[0] ? -$signed(mag) : $signed(mag);
endmodule

// File: rtl/lms_tap_mac.sv
module lms_tap_mac #(
   parameter int DATA_W    = 16,
   parameter int ACC_W     = 34,
   parameter int MUL_STAGE = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     tap_vld,
   input  logic signed [DATA_W-1:0] op_a,
   input  logic signed [DATA_W-1:0] op_b,
   output logic signed [ACC_W-1:0]  acc
);
   localparam int PROD_W = 2 * DATA_W;

   if (ACC_W < PROD_W) begin : g_bad_acc
      $error("lms_tap_mac: accumulator narrower than one product");
   end

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] add_prod;
   logic                     add_vld;

   assign prod = op_a * op_b;

   if (MUL_STAGE != 0) begin : g_staged
      logic signed [PROD_W-1:0] prod_q;
      logic                     vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_q <= '0;
            vld_q  <= 1'b0;
         end else begin
            prod_q <= prod;
            vld_q  <= tap_vld;
         end
      end
      assign add_prod = prod_q;
      assign add_vld  = vld_q;
   end else begin : g_direct
      assign add_prod = prod;
      assign add_vld  = tap_vld;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (clr)     acc <= '0;
      else if (add_vld) acc <= acc + ACC_W'(add_prod);
   end
endmodule

// File: rtl/lms_coef_bank.sv
module lms_coef_bank #(
   parameter int DATA_W = 16,
   parameter int TAPS   = 4,
   localparam int IDX_W = $clog2(TAPS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     wr_bank,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     upd_en,
   input  logic signed [DATA_W-1:0] new_sample,
   input  logic signed [DATA_W-1:0] delta,
   input  logic [IDX_W-1:0]         tap_idx,
   output logic signed [DATA_W-1:0] tap_hist,
   output logic signed [DATA_W-1:0] tap_wt,
   input  logic                     rd_bank,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [DATA_W-1:0]        rd_data
);
   logic signed [DATA_W-1:0] hist [TAPS];
   logic signed [DATA_W-1:0] wts  [TAPS];

   for (genvar i = 0; i < TAPS; i++) begin : g_tap
      logic signed [DATA_W-1:0] hist_next;
      if (i == TAPS - 1) begin : g_newest
         assign hist_next = new_sample;
      end else begin : g_older
         assign hist_next = hist[i+1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist[i] <= '0;
            wts[i]  <= '0;
         end else if (upd_en) begin
            hist[i] <= hist_next;
            wts[i]  <= hist[i][DATA_W-1] ? wts[i] - delta : wts[i] + delta;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            if (wr_bank) wts[i]  <= wr_data;
            else         hist[i] <= wr_data;
         end
      end
   end

   assign tap_hist = hist[tap_idx];
   assign tap_wt   = wts[tap_idx];
   assign rd_data  = rd_bank ? wts[rd_idx] : hist[rd_idx];
endmodule

// File: rtl/lms_sample_engine.sv
module lms_sample_engine #(
   parameter int DATA_W      = 16,
   parameter int TAPS        = 4,
   parameter int SF_W        = 4,
   parameter int QR_W        = 3,
   parameter int PRED_SHIFT  = 13,
   parameter int DELTA_SHIFT = 4,
   parameter int MUL_STAGE   = 0,
   localparam int IDX_W      = $clog2(TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SF_W-1:0]   sf_idx,
   input  logic [QR_W-1:0]   qr_code,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_bank,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] sample
);
   import lms_pkg::*;

   localparam int ACC_W  = 2 * DATA_W + IDX_W;
   localparam int LAST   = TAPS - 1 + MUL_STAGE;
   localparam int CNT_W  = $clog2(LAST + 2);
   localparam int SUM_W  = ACC_W + 1;
   localparam int HI_W   = SUM_W - DATA_W + 1;

   if (TAPS < 2 || (1 << IDX_W) != TAPS) begin : g_bad_taps
      $error("lms_sample_engine: TAPS must be a power of two >= 2");
   end
   if (MUL_STAGE != 0 && MUL_STAGE != 1) begin : g_bad_stage
      $error("lms_sample_engine: MUL_STAGE must be 0 or 1");
   end
   if (PRED_SHIFT >= ACC_W || DELTA_SHIFT >= DATA_W) begin : g_bad_shift
      $error("lms_sample_engine: shift exceeds operand width");
   end
   if (TAPS + 1 + MUL_STAGE > 40) begin : g_bad_budget
      $error("lms_sample_engine: decode latency exceeds the 40-cycle budget");
   end

   lms_state_e          state;
   logic [CNT_W-1:0]    cnt;
   logic [SF_W-1:0]     sf_q;
   logic [QR_W-1:0]     qr_q;

   logic                accept;
   logic                tap_vld;
   logic [IDX_W-1:0]    tap_idx;
   logic signed [DATA_W-1:0] tap_hist, tap_wt, resid, delta, sat_sample;
   logic signed [ACC_W-1:0]  acc, pred;
   logic signed [SUM_W-1:0]  sum;
   logic [HI_W-1:0]          sum_hi;

   assign busy    = (state != ST_IDLE);
   assign accept  = start && !busy;
   assign tap_vld = (state == ST_RUN) && (cnt < CNT_W'(TAPS));
   assign tap_idx = cnt[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sf_q   <= '0;
         qr_q   <= '0;
         done   <= 1'b0;
         sample <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               state <= ST_RUN;
               cnt   <= '0;
               sf_q  <= sf_idx;
               qr_q  <= qr_code;
            end
            ST_RUN: begin
               cnt <= cnt + 1'b1;
               if (cnt == CNT_W'(LAST)) state <= ST_FIN;
            end
            ST_FIN: begin
               state  <= ST_IDLE;
               done   <= 1'b1;
               sample <= sat_sample;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   lms_dequant_rom #(.DATA_W(DATA_W), .SF_W(SF_W), .QR_W(QR_W)) u_rom (
      .sf_idx (sf_q),
      .qr_code(qr_q),
      .resid  (resid)
   );

   lms_tap_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .MUL_STAGE(MUL_STAGE)) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .tap_vld(tap_vld),
      .op_a   (tap_hist),
      .op_b   (tap_wt),
      .acc    (acc)
   );

   // prediction, residual add and clamp to the sample range
   assign pred   = acc >>> PRED_SHIFT;
   assign sum    = SUM_W'(pred) + SUM_W'(resid);
   assign sum_hi = sum[SUM_W-1:DATA_W-1];
   always_comb begin
      if (sum_hi == '0 || sum_hi == '1)
         sat_sample = sum[DATA_W-1:0];
      else if (sum[SUM_W-1])
         sat_sample = {1'b1, {(DATA_W-1){1'b0}}};
      else
         sat_sample = {1'b0, {(DATA_W-1){1'b1}}};
   end
   assign delta = resid >>> DELTA_SHIFT;

   lms_coef_bank #(.DATA_W(DATA_W), .TAPS(TAPS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en && !busy),
      .wr_bank   (wr_bank),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .upd_en    (state == ST_FIN),
      .new_sample(sat_sample),
      .delta     (delta),
      .tap_idx   (tap_idx),
      .tap_hist  (tap_hist),
      .tap_wt    (tap_wt),
      .rd_bank   (rd_bank),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/lms_sample_engine_chk.sv
module lms_sample_engine_chk #(
   parameter int DATA_W    = 16,
   parameter int TAPS      = 4,
   parameter int MUL_STAGE = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] sample
);
   localparam int RUN_LEN = TAPS + 1 + MUL_STAGE;
   localparam int RC_W    = $clog2(RUN_LEN + 2);

   logic [RC_W-1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   // R8: an accepted start makes the engine busy next cycle
   a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

   // R8: a decode never stays busy past its fixed length
   a_r8_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_cnt < RC_W'(RUN_LEN));

   // R8: the end of a decode coincides with done
   a_r8_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R9: done only appears once the engine is idle again
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: done lasts a single cycle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: the output sample moves only with done
   a_r10_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sample) |-> done);
endmodule

bind lms_sample_engine lms_sample_engine_chk #(
   .DATA_W(DATA_W), .TAPS(TAPS), .MUL_STAGE(MUL_STAGE)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .sample(sample)
);

// File: tb/lms_sample_engine_bench.sv
module lms_sample_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int EXP_LAT    = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  sf_idx = '0;
   logic [2:0]  qr_code = '0;
   logic        wr_en = 1'b0;
   logic        wr_bank = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic        rd_bank = 1'b0;
   logic [1:0]  rd_idx = '0;
   logic [15:0] rd_data;
   logic        busy, done;
   logic [15:0] sample;

   int n_tests = 0;
   int n_fail  = 0;
   int mh[4];
   int mw[4];
   int seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   lms_sample_engine u_lms_sample_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .sf_idx(sf_idx), .qr_code(qr_code),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
      .busy(busy), .done(done), .sample(sample)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int w16(input int v);
      logic signed [15:0] t;
      t = v[15:0];
      return int'(t);
   endfunction

   function automatic int deq(input int s, input int q);
      real mults[4] = '{0.75, 2.5, 4.5, 7.0};
      int b, m;
      b = $rtoi($pow(real'(s + 1), 2.75) + 0.5);
      m = $rtoi(real'(b) * mults[q >> 1] + 0.5);
      return (q % 2 == 1) ? -m : m;
   endfunction

   function automatic int rnd16();
      seed = seed * 1103515245 + 12345;
      return w16(seed >>> 8);
   endfunction

   task automatic wr(input int bank, input int idx, input int val);
      @(negedge clk);
      wr_en = 1'b1; wr_bank = bank[0]; wr_idx = idx[1:0]; wr_data = val[15:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int bank, input int idx, output int val);
      rd_bank = bank[0]; rd_idx = idx[1:0];
      #1;
      val = w16(int'(rd_data));
   endtask

   task automatic load(input int h[4], input int w[4]);
      for (int i = 0; i < 4; i++) begin
         wr(0, i, h[i]); mh[i] = h[i];
         wr(1, i, w[i]); mw[i] = w[i];
      end
   endtask

   // R4 R5 R6 R7: bench model of one decode
   task automatic model(input int s, input int q, output int smp);
      longint acc;
      int r, dl;
      longint p;
      r = deq(s, q);
      acc = 0;
      for (int i = 0; i < 4; i++) acc += longint'(mh[i]) * longint'(mw[i]);
      p = (acc >>> 13) + r;
      if (p > 32767) p = 32767;
      if (p < -32768) p = -32768;
      smp = int'(p);
      dl = r >>> 4;
      for (int i = 0; i < 4; i++) mw[i] = w16(mw[i] + ((mh[i] < 0) ? -dl : dl));
      for (int i = 0; i < 3; i++) mh[i] = mh[i+1];
      mh[3] = smp;
   endtask

   task automatic check_state(input string tag);
      int v;
      for (int i = 0; i < 4; i++) begin
         rd(0, i, v); chk({tag, " R7 history"}, v, mh[i]);
         rd(1, i, v); chk({tag, " R6 weight"}, v, mw[i]);
      end
   endtask

   task automatic decode(input int s, input int q, input string tag);
      int exp_s, lat;
      model(s, q, exp_s);
      @(negedge clk);
      start = 1'b1; sf_idx = s[3:0]; qr_code = q[2:0];
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 60) begin
         @(negedge clk);
         lat++;
      end
      chk({tag, " R8 latency"}, lat, EXP_LAT);
      chk({tag, " R3 R4 R5 sample"}, w16(int'(sample)), exp_s);
      check_state(tag);
      @(negedge clk);
      chk({tag, " R10 done pulse"}, int'(done), 0);
      chk({tag, " R10 sample hold"}, w16(int'(sample)), exp_s);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      int hp[4], wp[4], v, exp_s, extra;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 sample", int'(sample), 0);
      for (int i = 0; i < 4; i++) begin mh[i] = 0; mw[i] = 0; end
      check_state("R1");

      // R2: write and read back both banks
      hp = '{100, -200, 300, -32768};
      wp = '{0, 0, -8192, 16384};
      load(hp, wp);
      check_state("R2");

      // R3 R4 R6 R7: full sweep of scale index and residual code
      for (int s = 0; s < 16; s++) begin
         for (int i = 0; i < 4; i++) begin
            hp[i] = rnd16() >>> 3;
            wp[i] = rnd16() >>> 2;
         end
         load(hp, wp);
         for (int q = 0; q < 8; q++) decode(s, q, "sweep");
      end

      // R5: positive saturation
      hp = '{32767, 32767, 32767, 32767};
      wp = '{32767, 32767, 32767, 32767};
      load(hp, wp);
      decode(15, 6, "R5 high");
      // R5: negative saturation
      hp = '{32767, 32767, 32767, 32767};
      wp = '{-32768, -32768, -32768, -32768};
      load(hp, wp);
      decode(15, 7, "R5 low");
      // R6: weight wrap at the 16-bit limit
      hp = '{1, 1, -1, -1};
      wp = '{32767, -32768, 32767, -32768};
      load(hp, wp);
      decode(15, 6, "R6 wrap");

      // R9: start and writes while busy are ignored
      hp = '{1000, -2000, 3000, -4000};
      wp = '{4096, -4096, 8192, 2048};
      load(hp, wp);
      model(3, 2, exp_s);
      @(negedge clk);
      start = 1'b1; sf_idx = 4'd3; qr_code = 3'd2;
      @(negedge clk);
      start = 1'b1; sf_idx = 4'd9; qr_code = 3'd5;
      wr_en = 1'b1; wr_bank = 1'b1; wr_idx = 2'd0; wr_data = 16'h1234;
      @(negedge clk);
      wr_bank = 1'b0; wr_idx = 2'd3; wr_data = 16'h4321;
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      while (!done) @(negedge clk);
      chk("R9 sample of first start", w16(int'(sample)), exp_s);
      check_state("R9 busy write");
      extra = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (busy || done) extra++;
      end
      chk("R9 no second decode", extra, 0);
      rd(1, 0, v);
      chk("R9 weight untouched", v, mw[0]);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule